// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Channel

This block is one memory-to-memory copy channel. Its work comes from a ring of descriptors held in memory. Each descriptor occupies 16 bytes starting at `TABLE_BASE`, and the ring is closed by a wrap flag. Every descriptor gives a source address, a destination address and a byte count.

Software sets a start bit in the mode register. The channel then walks the ring, fetching one descriptor at a time, copying its bytes and then finishing it off. Finishing a descriptor can mean writing the descriptor back, raising flags, stopping, or moving on to the next descriptor. A continuous setting makes the channel loop over the ring with no software help. Software learns that the channel has stopped by polling the start bit, which the channel clears itself. Completion is reported through two write-one-to-clear flags and a maskable level interrupt.

Descriptor fetches, byte reads and byte writes all share one synchronous memory port. A read returns its data in the cycle after the request.

Top module: `dma_ring_channel`

## Requirements
- R1: After reset, both registers read 0, `irq` is low and `mem_req` is low. The descriptor pointer is reset to `TABLE_BASE`.
- R2: A descriptor at pointer P is read as four little-endian 32-bit words: status at P (bits 15:0), length at P+4, source at P+8 and destination at P+12. The copy uses these values.
- R3: Data is copied one byte per transfer. Each transfer is a byte read of the source followed by a byte write of that value to the destination, and both addresses then increase by 1. A length of 0 completes the descriptor with no data transfer.
- R4: A descriptor whose status bit 15 (valid) is clear halts the channel. On halt, no data is moved, nothing is written back, mode bit 0 clears and DONE stays clear.
- R5: When continuous mode is off, a completed descriptor gets its status written back as a 32-bit word at P. The written value is the fetched status with bit 15 cleared.
- R6: After a descriptor with status bit 13 (wrap) set, the pointer returns to `TABLE_BASE`. After any other descriptor it advances by 16.
- R7: When continuous mode is off, completing a descriptor with status bit 11 (last) set stops the channel. Mode bit 0 clears and status bit 0 (DONE) is set.
- R8: A descriptor with status bit 9 (continuous) set is not written back and its last flag is ignored. The channel keeps cycling until software clears mode bit 0, the channel is reset, or an invalid descriptor is met.
- R9: Completing a descriptor with status bit 12 (interrupt) set sets status bit 1 (AD).
- R10: Writing 1 to a status bit (address 1) clears that bit. `irq` equals AD AND mode bit 1 (mask).
- R11: Writing mode bit 0 (address 0) as 1 while idle starts the channel. While the channel runs, a mode write can only clear bit 0. Clearing it mid-copy stops the channel after the current byte, with no write-back and no DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode (bit0 start, bit1 mask), 1 = status (bit0 DONE, bit1 AD) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit word access, 0 = byte access on bits 7:0 |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A wrong internal state shows up at the memory port within a few cycles. A corrupted descriptor field shows up as a misdirected or mis-valued byte write on the very next data transfer. A pointer that mishandles wrap fetches the wrong descriptor, so the next copy goes astray or the channel halts early. A mistaken continuous or last decision shows as an extra or missing status write-back and a wrong DONE value the moment the channel stops. The scoreboard therefore compares every write on the port, in order, against a sequence derived from the descriptors. Register reads after each stop catch flag errors.

// File: rtl/dma_ring_channel.sv
module dma_ring_channel #(
  parameter logic [31:0] TABLE_BASE = 32'h0000_0000,
  parameter int          BD_BYTES   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_word,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);

  localparam logic [31:0] STRIDE = 32'(BD_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FLOAD, S_RD, S_WR, S_FIN} state_t;

  state_t      state;
  logic [1:0]  fi;
  logic        str, imask, done_f, ad_f;
  logic [31:0] ptr, len, src, dst;
  logic [15:0] st;

  wire f_wrap = st[13];
  wire f_int  = st[12];
  wire f_last = st[11];
  wire f_cont = st[9];

  wire mode_wr = reg_wr && !reg_addr;
  wire stat_wr = reg_wr &&  reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fi     <= '0;
      str    <= 1'b0;
      imask  <= 1'b0;
      done_f <= 1'b0;
      ad_f   <= 1'b0;
      ptr    <= TABLE_BASE;
      len    <= '0;
      src    <= '0;
      dst    <= '0;
      st     <= '0;
    end else begin
      if (mode_wr) begin
        imask <= reg_wdata[1];
        if (state == S_IDLE) begin
          str <= reg_wdata[0];
          if (reg_wdata[0]) begin
            state <= S_FETCH;
            fi    <= '0;
          end
        end else begin
          str <= str & reg_wdata[0];
        end
      end
      if (stat_wr) begin
        done_f <= done_f & ~reg_wdata[0];
        ad_f   <= ad_f   & ~reg_wdata[1];
      end

      case (state)
        S_FETCH: state <= str ? S_FLOAD : S_IDLE;
        S_FLOAD: begin
          case (fi)
            2'd0: st  <= mem_rdata[15:0];
            2'd1: len <= mem_rdata;
            2'd2: src <= mem_rdata;
            default: dst <= mem_rdata;
          endcase
          if (fi == 2'd0 && !mem_rdata[15]) begin
            str   <= 1'b0;
            state <= S_IDLE;
          end else if (fi == 2'd3) begin
            state <= (len == '0) ? S_FIN : S_RD;
          end else begin
            fi    <= fi + 2'd1;
            state <= S_FETCH;
          end
        end
        S_RD: state <= str ? S_WR : S_IDLE;
        S_WR: begin
          len   <= len - 32'd1;
          src   <= src + 32'd1;
          dst   <= dst + 32'd1;
          state <= (len == 32'd1) ? S_FIN : S_RD;
        end
        S_FIN: begin
          if (f_int) ad_f <= 1'b1;
          ptr <= f_wrap ? TABLE_BASE : ptr + STRIDE;
          fi  <= '0;
          if (!f_cont && f_last) begin
            done_f <= 1'b1;
            str    <= 1'b0;
            state  <= S_IDLE;
          end else begin
            state <= str ? S_FETCH : S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_req  = (state == S_FETCH) || (state == S_RD) || (state == S_WR) ||
                    (state == S_FIN && !f_cont);
  assign mem_we   = (state == S_WR) || (state == S_FIN);
  assign mem_word = (state == S_FETCH) || (state == S_FIN);

  always_comb begin
    mem_addr  = ptr;
    mem_wdata = '0;
    case (state)
      S_FETCH: mem_addr = ptr + {28'd0, fi, 2'b00};
      S_RD:    mem_addr = src;
      S_WR: begin
        mem_addr  = dst;
        mem_wdata = {24'd0, mem_rdata[7:0]};
      end
      S_FIN:   mem_wdata = {16'd0, st & 16'h7FFF};
      default: ;
    endcase
  end

  assign reg_rdata = reg_addr ? {14'd0, ad_f, done_f} : {14'd0, imask, str};
  assign irq       = ad_f & imask;

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[15:2];

  // R11
  idle_nostr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !str);

  // R5
  wb_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_word) |-> !mem_wdata[15]);

  // R3
  byte_wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_word) |-> $past(mem_req && !mem_we && !mem_word));

  // R7
  done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> (!str && state == S_IDLE));

  // R9
  ad_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_f) |-> $past(state == S_FIN && f_int));

endmodule

// File: tb/tb_dma_ring_channel.sv
module tb_dma_ring_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, mem_req, mem_we, mem_word;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  dma_ring_channel dut (.*);

  always #2 clk = ~clk;

  logic [7:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_word) begin
          for (int k = 0; k < 4; k++) mem[(mem_addr[11:0] + 12'(k))] = mem_wdata[8*k +: 8];
        end else begin
          mem[mem_addr[11:0]] = mem_wdata[7:0];
        end
      end else if (mem_word) begin
        mem_rdata <= {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                      mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
      end else begin
        mem_rdata <= {24'd0, mem[mem_addr[11:0]]};
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  logic [64:0] exp_q[$];
  string       tag_q[$];

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic exp_byte(input logic [31:0] a, input string tag);
    exp_q.push_back({1'b0, a, 24'd0, pat(a - 32'h100)});
    tag_q.push_back(tag);
  endtask

  task automatic exp_word(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({1'b1, a, d});
    tag_q.push_back(tag);
  endtask

  // monitor: compare every memory write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
      end else begin
        logic [64:0] e;
        string t;
        logic [31:0] d;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        d = mem_word ? mem_wdata : {24'd0, mem_wdata[7:0]};
        check(mem_word == e[64], {t, " width"}, {31'd0, mem_word}, {31'd0, e[64]});
        check(mem_addr == e[63:32], {t, " addr"}, mem_addr, e[63:32]);
        check(d == e[31:0], {t, " data"}, d, e[31:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      report();
    end
  end

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) mem[a[11:0] + 12'(k)] = d[8*k +: 8];
  endtask

  task automatic put_bd(input int idx, input logic [15:0] s, input logic [31:0] l,
                        input logic [31:0] sa, input logic [31:0] da);
    put_word(32'(idx * 16),      {16'd0, s});
    put_word(32'(idx * 16 + 4),  l);
    put_word(32'(idx * 16 + 8),  sa);
    put_word(32'(idx * 16 + 12), da);
  endtask

  task automatic reg_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == e, tag, {16'd0, reg_rdata}, {16'd0, e});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      reg_addr = 1'b0;
      #1;
      if (!reg_rdata[0]) break;
    end
  endtask

  task automatic abort_after(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (mem_req && mem_we && !mem_word) seen++;
    end
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0000;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic settle_empty(input string tag);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = (a >= 32'h100) ? pat(32'(a) - 32'h100 + 32'h100 - 32'h100) : 8'h00;
    for (int a = 32'h100; a < 4096; a++) mem[a] = pat(32'(a) - 32'h100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_check(1'b0, 16'h0000, "R1 mode after reset");
    reg_check(1'b1, 16'h0000, "R1 status after reset");
    check(!irq && !mem_req, "R1 irq/mem_req idle", {30'd0, irq, mem_req}, 32'd0);

    // chain of three: plain, zero length with interrupt, wrap+last
    put_bd(0, 16'h8000, 32'd3, 32'h0000_0200, 32'h0000_0300);
    put_bd(1, 16'h9000, 32'd0, 32'h0,         32'h0);
    put_bd(2, 16'hA800, 32'd2, 32'h0000_0210, 32'h0000_0310);
    for (int i = 0; i < 3; i++) exp_byte(32'h300 + 32'(i), "R2/R3 copy bd0");
    exp_word(32'h000, 32'h0000_0000, "R5 writeback bd0");
    exp_word(32'h010, 32'h0000_1000, "R3/R5 zero length bd1");
    exp_byte(32'h310, "R3 copy bd2");
    exp_byte(32'h311, "R3 copy bd2");
    exp_word(32'h020, 32'h0000_2800, "R5 writeback bd2");
    reg_write(1'b0, 16'h0003);
    wait_idle();
    reg_check(1'b1, 16'h0003, "R7/R9 DONE and AD after last");
    check(irq, "R10 irq with mask", {31'd0, irq}, 32'd1);
    reg_write(1'b1, 16'h0002);
    reg_check(1'b1, 16'h0001, "R10 W1C clears AD only");
    check(!irq, "R10 irq drops", {31'd0, irq}, 32'd0);
    reg_write(1'b1, 16'h0001);
    reg_check(1'b1, 16'h0000, "R10 W1C clears DONE");
    check(exp_q.size() == 0, "R3/R5 chain writes all seen", 32'(exp_q.size()), 32'd0);

    // R6 wrap returned pointer to table start
    put_bd(0, 16'h8800, 32'd1, 32'h0000_0220, 32'h0000_0320);
    exp_byte(32'h320, "R6 after wrap bd0");
    exp_word(32'h000, 32'h0000_0800, "R6 writeback bd0");
    reg_write(1'b0, 16'h0001);
    wait_idle();
    reg_check(1'b1, 16'h0001, "R6/R7 DONE after wrapped bd0");
    reg_write(1'b1, 16'h0001);

    // R4 halt: pointer now at bd1, invalidated by write-back
    reg_write(1'b0, 16'h0001);
    wait_idle();
    settle_empty("R4 no transfer on invalid");
    reg_check(1'b0, 16'h0000, "R4 STR cleared on halt");
    reg_check(1'b1, 16'h0000, "R4 DONE stays clear");

    // R8 continuous ring, stopped by software mid-descriptor
    do_reset();
    put_bd(0, 16'h8A00, 32'd2, 32'h0000_0400, 32'h0000_0500);
    put_bd(1, 16'hA200, 32'd1, 32'h0000_0410, 32'h0000_0510);
    exp_byte(32'h500, "R8 loop1 bd0");
    exp_byte(32'h501, "R8 loop1 bd0");
    exp_byte(32'h510, "R8 loop1 bd1");
    exp_byte(32'h500, "R8 loop2 bd0");
    reg_write(1'b0, 16'h0001);
    abort_after(4);
    settle_empty("R8/R11 stop after current byte");
    reg_check(1'b0, 16'h0000, "R11 STR clear after abort");
    reg_check(1'b1, 16'h0000, "R8/R11 no DONE in continuous stop");
    check({mem[1], mem[0]} == 16'h8A00, "R8 no writeback in continuous",
          {16'd0, mem[1], mem[0]}, 32'h8A00);

    // R11 abort of a non-continuous descriptor
    do_reset();
    put_bd(0, 16'h8800, 32'd6, 32'h0000_0600, 32'h0000_0700);
    exp_byte(32'h700, "R11 partial copy");
    exp_byte(32'h701, "R11 partial copy");
    reg_write(1'b0, 16'h0001);
    abort_after(2);
    settle_empty("R11 two bytes only");
    reg_check(1'b1, 16'h0000, "R11 no DONE on abort");
    check({mem[1], mem[0]} == 16'h8800, "R11 no writeback on abort",
          {16'd0, mem[1], mem[0]}, 32'h8800);

    // R9/R10 AD with mask off, then mask on
    do_reset();
    put_bd(0, 16'h9800, 32'd1, 32'h0000_0620, 32'h0000_0720);
    exp_byte(32'h720, "R9 copy");
    exp_word(32'h000, 32'h0000_1800, "R9 writeback");
    reg_write(1'b0, 16'h0001);
    wait_idle();
    reg_check(1'b1, 16'h0003, "R9 AD set by interrupt flag");
    check(!irq, "R10 irq masked", {31'd0, irq}, 32'd0);
    reg_write(1'b0, 16'h0002);
    #1;
    check(irq, "R10 irq after unmask", {31'd0, irq}, 32'd1);
    reg_check(1'b0, 16'h0002, "R11 mask write does not start");

    check(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    report();
  end
endmodule